// File: doc/BRIEF.md
# EDO DRAM Controller with Refresh Scheduler

This block sits between a simple host request port and one x16 EDO DRAM device. Each host request carries a 22-bit word address, 16 bits of write data, two byte enables and a read/write flag, and is taken on a valid/ready handshake. The controller splits the address into a row and a column. It drives the multiplexed 12-bit address bus and sequences the row strobe, the two byte-lane column strobes, write enable and output enable. Read data comes back on a registered port with a single-cycle valid pulse.

The row stays open after an access. A later request to the same row is served by a column-only cycle, and a request to any other row first closes the open row. A free-running interval timer raises a refresh request every `REF_INTERVAL` clock cycles. That request wins over host traffic. The controller finishes the access in flight, closes the row, waits out the precharge time and then runs a column-before-row refresh, which needs no refresh address. Every timing value is a parameter in clock cycles.

Top module: `edo_ctrl`

## Requirements
- R1: The row strobe falls while the bus carries address bits 21..10, and the column strobes fall while bus bits 9..0 carry address bits 9..0 and bus bits 11..10 are zero.
- R2: Byte enable bit 0 gates the lower-lane column strobe (data bits 7..0) and bit 1 gates the upper-lane strobe (data bits 15..8). A lane whose enable is 0 keeps its strobe high for the whole access, so its stored byte is unchanged.
- R3: One column-before-row refresh is issued every `REF_INTERVAL` cycles on average, whether the port is idle or busy.
- R4: In a refresh, both column strobes are low at least one cycle before the row strobe falls, and write enable is high throughout.
- R5: A write drives write enable low at least one cycle before a column strobe falls. The data bus is driven only during writes, and output enable is high whenever it is driven.
- R6: A request to the open row, made with no refresh pending, causes no new row strobe fall. A request to another row, or the first request after a refresh, opens the row with exactly one row strobe fall.
- R7: The row-to-column delay is at least `T_RCD` cycles, the column strobe low width is at least `T_CAS` cycles, and the row strobe stays high at least `T_RP` cycles before each fall.
- R8: Read data is captured `T_CAP` cycles after the column strobe falls. It is presented with a `rd_valid` pulse lasting one cycle, and output enable stays low until the capture.
- R9: Once a refresh is pending, no host request is accepted until the refresh has started. The gap between two refreshes never exceeds `REF_INTERVAL` plus the length of one access.
- R10: During and after reset, all strobes, write enable and output enable are high, the data bus is not driven and `rd_valid` is low. After reset, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in bits 21..10 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Captured read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
A stale open-row register would show up on the next same-row request. Either an extra row strobe fall appears within three cycles of acceptance, or the row is not reopened and the read returns data from the wrong row. A stuck or lost refresh-pending flag would show at the ports as a missing refresh or a missing reopen after a refresh, seen as soon as one refresh interval has passed. A counter that is off by one changes strobe spacing or the capture cycle on the very first access, and reads then return the memory model's bus value from the wrong cycle.

// File: rtl/edo_ctrl.sv
module edo_ctrl #(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int DQ_W         = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CAP        = 3,
  parameter int T_RP         = 2,
  parameter int T_RREF       = 4,
  parameter int REF_INTERVAL = 3120
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]    req_wdata,
  input  logic [DQ_W/8-1:0]  req_be,
  output logic               rd_valid,
  output logic [DQ_W-1:0]    rd_data,
  output logic               dram_ras_n,
  output logic               dram_lcas_n,
  output logic               dram_ucas_n,
  output logic               dram_we_n,
  output logic               dram_oe_n,
  output logic [ROW_W-1:0]   dram_addr,
  output logic [DQ_W-1:0]    dram_dq_out,
  output logic               dram_dq_oe,
  input  logic [DQ_W-1:0]    dram_dq_in
);
  localparam int AW = ROW_W + COL_W;
  localparam int BW = DQ_W / 8;
  localparam int CW = $clog2(T_RCD + T_CAS + T_CAP + T_RP + T_RREF + 2);
  localparam int RW = $clog2(REF_INTERVAL);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ACT, S_COL, S_CASL, S_HOLD, S_OPEN, S_RCAS, S_RREF
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [RW-1:0]    ref_cnt;
  logic             ref_pend, have_req, q_we;
  logic [ROW_W-1:0] q_row, open_row;
  logic [COL_W-1:0] q_col;
  logic [DQ_W-1:0]  q_wdata;
  logic [BW-1:0]    q_be;

  wire accept   = req_valid && req_ready;
  wire ref_exp  = ref_cnt == RW'(REF_INTERVAL - 1);
  wire ref_go   = ref_pend && (st == S_IDLE || (st == S_PRE && cnt == CW'(T_RP - 1)));
  wire row_hit  = req_addr[AW-1:COL_W] == open_row;
  wire in_col   = st == S_COL || st == S_CASL;
  wire ref_cas  = st == S_RCAS || st == S_RREF;

  assign req_ready   = (st == S_IDLE || st == S_OPEN) && !ref_pend;
  assign dram_ras_n  = !(st inside {S_ACT, S_COL, S_CASL, S_HOLD, S_OPEN, S_RREF});
  assign dram_lcas_n = !((st == S_CASL && q_be[0]) || ref_cas);
  assign dram_ucas_n = !((st == S_CASL && q_be[BW-1]) || ref_cas);
  assign dram_we_n   = !(q_we && in_col);
  assign dram_oe_n   = !(!q_we && (in_col || st == S_HOLD));
  assign dram_addr   = (st == S_ACT) ? q_row : ROW_W'(q_col);
  assign dram_dq_out = q_wdata;
  assign dram_dq_oe  = q_we && in_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ref_cnt <= '0; ref_pend <= 1'b0;
      have_req <= 1'b0; q_we <= 1'b0; q_row <= '0; q_col <= '0;
      q_wdata <= '0; q_be <= '0; open_row <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      ref_cnt  <= ref_exp ? '0 : ref_cnt + 1'b1;
      ref_pend <= ref_exp || (ref_pend && !ref_go);
      if (accept) begin
        q_we <= req_we; q_row <= req_addr[AW-1:COL_W]; q_col <= req_addr[COL_W-1:0];
        q_wdata <= req_wdata; q_be <= req_be; have_req <= 1'b1;
      end
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pend) st <= S_RCAS;
          else if (accept) st <= S_ACT;
        end
        S_OPEN: begin
          cnt <= '0;
          if (ref_pend) st <= S_PRE;
          else if (accept) st <= row_hit ? S_COL : S_PRE;
        end
        S_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_RP - 1)) begin
            cnt <= '0;
            st  <= ref_pend ? S_RCAS : (have_req ? S_ACT : S_IDLE);
          end
        end
        S_ACT: begin
          open_row <= q_row;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_RCD - 1)) begin cnt <= '0; st <= S_COL; end
        end
        S_COL: begin cnt <= '0; st <= S_CASL; end
        S_CASL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_CAS - 1)) begin
            if (q_we) begin st <= S_OPEN; have_req <= 1'b0; end
            else if (T_CAP == T_CAS) begin
              st <= S_OPEN; have_req <= 1'b0; rd_data <= dram_dq_in; rd_valid <= 1'b1;
            end else st <= S_HOLD;
          end
        end
        S_HOLD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_CAP - 1)) begin
            st <= S_OPEN; have_req <= 1'b0; rd_data <= dram_dq_in; rd_valid <= 1'b1;
          end
        end
        S_RCAS: begin cnt <= '0; st <= S_RREF; end
        S_RREF: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(T_RREF - 1)) begin cnt <= '0; st <= S_PRE; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] ras_hi;
  always_ff @(posedge clk) begin
    if (!rst_n) ras_hi <= CW'(T_RP);
    else if (!dram_ras_n) ras_hi <= '0;
    else if (ras_hi != '1) ras_hi <= ras_hi + 1'b1;
  end

  wire cas_all_hi = dram_lcas_n && dram_ucas_n;

  p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ras_hi >= CW'(T_RP));
  p_early_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_all_hi) && !dram_we_n |-> $past(!dram_we_n));
  p_drive_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> dram_oe_n);
  p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) && !dram_lcas_n |-> $past(!dram_lcas_n && !dram_ucas_n) && dram_we_n);
  p_capture_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!dram_oe_n));
  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_no_accept_in_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_lcas_n && !dram_ucas_n && dram_ras_n |-> !req_ready);
endmodule

// File: tb/edo_ctrl_test.sv
module edo_ctrl_test;
  localparam int T_RCD = 2, T_CAS = 2, T_CAP = 3, T_RP = 2, T_RREF = 4, RI = 300;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0, dram_dq_in = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, dq_out;
  logic [11:0] addr;

  edo_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CAP(T_CAP), .T_RP(T_RP),
             .T_RREF(T_RREF), .REF_INTERVAL(RI)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_lcas_n(lcas_n),
    .dram_ucas_n(ucas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dram_dq_in));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  // memory model and strobe monitor
  logic [15:0] mem [int];
  int ncyc = 0, t_rr = -100, t_rf = 0, t_cf = 0, last_cbr = 0, max_gap = 0;
  int act_falls = 0, cbr = 0, lfalls = 0, ufalls = 0;
  logic [11:0] row_q = '0, ras_row = '0, cas_col = '0;
  logic p_ras = 1, p_l = 1, p_u = 1, p_we = 1, p_oe = 1;
  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (p_l && !lcas_n) lfalls++;
      if (p_u && !ucas_n) ufalls++;
      if (p_ras && !ras_n) begin
        chk(ncyc - t_rr >= T_RP, "R7 precharge", ncyc - t_rr, T_RP);
        if (!lcas_n) begin
          cbr++;
          if (cbr > 1 && ncyc - last_cbr > max_gap) max_gap = ncyc - last_cbr;
          last_cbr = ncyc;
          chk(!p_l && !p_u && we_n, "R4 cbr order", {p_l, p_u, we_n}, 1);
        end else begin
          act_falls++; t_rf = ncyc; row_q = addr; ras_row = addr;
        end
      end
      if (!p_ras && ras_n) t_rr = ncyc;
      if (p_l && p_u && !(lcas_n && ucas_n)) begin
        if (ras_n) chk(we_n, "R4 we high", we_n, 1);
        else begin
          t_cf = ncyc; cas_col = addr;
          chk(ncyc - t_rf >= T_RCD, "R7 rcd", ncyc - t_rf, T_RCD);
          if (!we_n) begin
            chk(!p_we && dq_oe, "R5 early write", {p_we, dq_oe}, 1);
            if (!mem.exists(int'({row_q, addr[9:0]}))) mem[int'({row_q, addr[9:0]})] = 16'h0;
            if (!lcas_n) mem[int'({row_q, addr[9:0]})][7:0] = dq_out[7:0];
            if (!ucas_n) mem[int'({row_q, addr[9:0]})][15:8] = dq_out[15:8];
          end else if (mem.exists(int'({row_q, addr[9:0]})))
            dram_dq_in <= mem[int'({row_q, addr[9:0]})];
          else dram_dq_in <= 16'h0;
        end
      end
      if (!(p_l && p_u) && lcas_n && ucas_n && !ras_n)
        chk(ncyc - t_cf >= T_CAS, "R7 cas width", ncyc - t_cf, T_CAS);
      if (dq_oe && !oe_n) chk(0, "R5 bus clash", 1, 0);
      if (rd_valid) begin
        chk(ncyc - t_cf == T_CAP, "R8 capture latency", ncyc - t_cf, T_CAP);
        chk(!p_oe, "R8 oe held", p_oe, 0);
      end
    end
    p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n; p_oe = oe_n;
  end

  task automatic do_req(input bit we, input logic [21:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd_wait(output logic [15:0] v);
    while (!rd_valid) @(negedge clk);
    v = rd_data;
  endtask

  // {we, addr, wdata, be, expected read}
  localparam logic [56:0] VEC [10] = '{
    {1'b1, 22'h001403, 16'h1234, 2'b11, 16'h0000},
    {1'b1, 22'h001404, 16'h5678, 2'b11, 16'h0000},
    {1'b0, 22'h001403, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 22'h001403, 16'h00AB, 2'b01, 16'h0000},
    {1'b0, 22'h001403, 16'h0000, 2'b11, 16'h12AB},
    {1'b1, 22'h001403, 16'hCD00, 2'b10, 16'h0000},
    {1'b0, 22'h001403, 16'h0000, 2'b11, 16'hCDAB},
    {1'b1, 22'h002403, 16'h9999, 2'b11, 16'h0000},
    {1'b0, 22'h001404, 16'h0000, 2'b11, 16'h5678},
    {1'b0, 22'h002403, 16'h0000, 2'b11, 16'h9999}};

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int n0, a0, l0, u0, t0;
    repeat (4) @(negedge clk);
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n && !dq_oe && !rd_valid, "R10 reset outputs",
        {ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe, rd_valid}, 7'b1111100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && ras_n && !rd_valid, "R10 ready after reset", {req_ready, ras_n, rd_valid}, 3'b110);

    for (int i = 0; i < 10; i++) begin
      #1 l0 = lfalls; u0 = ufalls;
      do_req(VEC[i][56], VEC[i][55:34], VEC[i][33:18], VEC[i][17:16]);
      if (!VEC[i][56]) begin
        rd_wait(v);
        chk(v == VEC[i][15:0], (i == 4 || i == 6) ? "R2 byte merge" : "R1 readback", v, VEC[i][15:0]);
      end
      if (i == 3) begin repeat (6) @(negedge clk); #1 chk(ufalls == u0, "R2 upper idle", ufalls - u0, 0); end
      if (i == 5) begin repeat (6) @(negedge clk); #1 chk(lfalls == l0, "R2 lower idle", lfalls - l0, 0); end
    end

    do_req(0, 22'h2A51F3, 16'h0, 2'b11);
    rd_wait(v);
    chk(ras_row == (22'h2A51F3 >> 10), "R1 row bits", ras_row, 22'h2A51F3 >> 10);
    chk(cas_col == 12'h1F3, "R1 column bits", cas_col, 12'h1F3);

    n0 = cbr; while (cbr == n0) @(negedge clk);
    #1 a0 = act_falls;
    do_req(1, {12'd7, 10'd1}, 16'h1111, 2'b11);
    do_req(1, {12'd7, 10'd2}, 16'h2222, 2'b11);
    repeat (6) @(negedge clk);
    #1 chk(act_falls - a0 == 1, "R6 page hit", act_falls - a0, 1);
    do_req(0, {12'd8, 10'd2}, 16'h0, 2'b11);
    rd_wait(v);
    #1 chk(act_falls - a0 == 2, "R6 row miss", act_falls - a0, 2);

    n0 = cbr; while (cbr == n0) @(negedge clk);
    #1 n0 = cbr;
    repeat (RI * 10 + RI / 2) @(negedge clk);
    #1 chk(cbr - n0 == 10, "R3 idle refresh rate", cbr - n0, 10);

    #1 n0 = cbr; a0 = act_falls; t0 = ncyc; max_gap = 0;
    for (int k = 0; ncyc < t0 + RI * 10; k++) do_req(1, {12'd3, 10'(k)}, 16'(k), 2'b11);
    do_req(1, {12'd3, 10'd0}, 16'h0, 2'b11);
    #1 n0 = cbr - n0;
    repeat (8) @(negedge clk);
    #1 chk(n0 >= 9 && n0 <= 11, "R3 busy refresh rate", n0, 10);
    chk(max_gap <= RI + 16, "R9 refresh priority gap", max_gap, RI);
    chk(act_falls - a0 == n0 + 1, "R6 reopen after refresh", act_falls - a0, n0 + 1);
    do_req(0, {12'd3, 10'd0}, 16'h0, 2'b11);
    rd_wait(v);
    chk(v == 16'h0, "R1 stream readback", v, 0);
    finish_run();
  end
endmodule